// File: doc/BRIEF.md
# Acknowledge-Selected DMA Word Port

This block is the device side of a request/acknowledge DMA handshake for a USB device controller's receive path. When an endpoint buffer reports a finished packet, the block raises a DMA request towards an external DMA controller. The DMA controller answers with an acknowledge strobe. That strobe alone selects the device: there is no chip-select and no address decode. While acknowledge and the active-low read strobe are both asserted, the block drives the current 16-bit buffer word onto a shared tri-state data bus. When the strobe ends, it steps to the next word.

A configuration input turns the acknowledge-only mode on. While it is off, the block raises no request and ignores acknowledge entirely. A second configuration input picks the release policy. In single-cycle mode the request is withdrawn after every word and raised again once acknowledge has been released. In burst mode the request stays up until the final word of the packet has gone out. The endpoint buffer is seen as a plain word-read port. `buf_addr` is the word index and `buf_data` returns that word in the same cycle. `pkt_done` tells the buffer that the packet has been consumed.

Top module: `dma_ack_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `dma_req`, `pkt_done` and `dbus_oe` go low and `buf_addr` returns to 0.
- R2: With `cfg_ack_only`=1, the block is idle and `pkt_valid`=1 with a non-zero `pkt_words` sampled at a clock edge. `dma_req` is then high after that edge, and `buf_addr` starts at 0.
- R3: With `cfg_ack_only`=0, `dma_req` stays low. Asserting `dma_ack` with `rd_n` low then leaves `dbus_oe` low and `buf_addr` unchanged.
- R4: During a transfer, while `dma_ack`=1 and `rd_n`=0, `dbus_oe` is 1 in the same cycle and `dbus` carries `buf_data` for the current `buf_addr`.
- R5: The acknowledged strobe ends when `dma_ack`=1 with `rd_n`=0 stops holding. At the next clock edge `buf_addr` advances by exactly one.
- R6: Single-cycle mode (`cfg_burst`=0): `dma_req` is low after the edge that ends a word. It is high again one edge after `dma_ack` is seen low, provided words remain.
- R7: Burst mode (`cfg_burst`=1): `dma_req` stays high across word boundaries until the last word ends.
- R8: Releasing `dma_ack` drops `dbus_oe` in the same cycle, even if `rd_n` is still low, so the bus returns to high impedance.
- R9: After the last word ends, `pkt_done` is high for exactly one cycle and `dma_req` is low. No new request is raised until `pkt_valid` has been seen low and then high again.
- R10: A 32-word (64-byte) packet is delivered as 32 strobes, with the words in buffer order from index 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ack_only | input | 1 | Enables acknowledge-only DMA operation |
| cfg_burst | input | 1 | 1 = hold request for whole packet, 0 = release after each word |
| pkt_valid | input | 1 | Endpoint buffer holds a received packet |
| pkt_words | input | CNT_W (6) | Packet length in 16-bit words, 1..MAX_WORDS |
| pkt_done | output | 1 | One-cycle pulse when the last word has been taken |
| buf_addr | output | ADDR_W (5) | Word index into the endpoint buffer |
| buf_data | input | DATA_W (16) | Buffer word at `buf_addr` |
| dma_req | output | 1 | DMA request to the DMA controller |
| dma_ack | input | 1 | DMA acknowledge; selects the device |
| rd_n | input | 1 | Active-low read strobe |
| dbus_oe | output | 1 | High while the block drives `dbus` |
| dbus | inout | DATA_W (16) | Shared tri-state data bus |

## Verification
Bus drive and its release are combinational on `dma_ack` and `rd_n`, so the bench checks `dbus_oe` and the scoreboard checks `dbus` one nanosecond after the falling edge where it changed those inputs. Request rise, word step, request drop and `pkt_done` are all registered one edge after their cause. The bench therefore reads each of them at the falling edge that follows that rising edge. The single-cycle re-request needs one further edge after acknowledge is released, and the bench samples it there.

// File: rtl/dma_ack_pkg.sv
// Shared types for the acknowledge-selected DMA word port.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dma_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a packet
        ST_XFER = 2'd1,   // words remain to be moved
        ST_HOLD = 2'd2    // packet consumed, waiting for pkt_valid to fall
    } dma_state_e;
endpackage

// File: rtl/dma_word_ctr.sv
// Word counter: holds the number of words left in the packet and the
// buffer read index. Assumes load and step never coincide, and that the
// loaded count lies within 1..MAX_WORDS.
module dma_word_ctr #(
    parameter int MAX_WORDS = 32,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1),
    parameter int ADDR_W    = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_words,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [CNT_W-1:0] remain;

    // Load a new packet length or consume one word per completed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            addr   <= '0;
        end else if (load) begin
            remain <= load_words;
            addr   <= '0;
        end else if (step && remain != '0) begin
            remain <= remain - 1'b1;
            addr   <= addr + 1'b1;
        end
    end

    // Flag the final word of the packet.
    always_comb last = (remain == CNT_W'(1));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && remain != '0) |=> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

// File: rtl/dma_bus_strobe.sv
// Strobe tracker and bus driver: decides when the block owns the data bus
// and flags the end of each acknowledged read strobe. Assumes dma_ack and
// rd_n are already synchronous to clk.
module dma_bus_strobe #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              dma_ack,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] buf_data,
    output logic              drive,
    output logic [DATA_W-1:0] drive_data,
    output logic              word_end
);
    logic strobe_now;
    logic strobe_prev;

    // Decide whether acknowledge and read strobe currently select the block.
    always_comb strobe_now = enable && dma_ack && !rd_n;

    // Remember whether the previous cycle had an acknowledged strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev <= 1'b0;
        else        strobe_prev <= strobe_now;
    end

    // Produce bus drive and the trailing-edge word marker.
    always_comb begin
        drive      = strobe_now;
        drive_data = buf_data;
        word_end   = strobe_prev && !strobe_now;
    end

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drive) && !dma_ack) |-> word_end);
endmodule

// File: rtl/dma_req_fsm.sv
// Request controller: walks idle, transfer and hold states, generates the
// DMA request according to the single/burst policy and pulses completion.
// Assumes word_end only occurs while in the transfer state.
module dma_req_fsm
    import dma_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       cfg_burst,
    input  logic       pkt_valid,
    input  logic       pkt_nonzero,
    input  logic       dma_ack,
    input  logic       word_end,
    input  logic       last,
    output dma_state_e state,
    output logic       load,
    output logic       dma_req,
    output logic       pkt_done
);
    // Start a packet when enabled, idle and a non-empty packet is present.
    always_comb load = cfg_en && (state == ST_IDLE) && pkt_valid && pkt_nonzero;

    // State, request and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dma_req  <= 1'b0;
            pkt_done <= 1'b0;
        end else begin
            pkt_done <= 1'b0;
            if (!cfg_en) begin
                state   <= ST_IDLE;
                dma_req <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (load) begin
                        state   <= ST_XFER;
                        dma_req <= 1'b1;
                    end
                    ST_XFER: if (word_end) begin
                        if (last) begin
                            state    <= ST_HOLD;
                            dma_req  <= 1'b0;
                            pkt_done <= 1'b1;
                        end else begin
                            dma_req  <= cfg_burst;
                        end
                    end else if (!dma_req && !dma_ack) begin
                        dma_req <= 1'b1;
                    end
                    ST_HOLD: if (!pkt_valid) state <= ST_IDLE;
                    default: begin
                        state   <= ST_IDLE;
                        dma_req <= 1'b0;
                    end
                endcase
            end
        end
    end

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !dma_req);
    assert_request_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dma_req);
    assert_single_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !cfg_burst) |=> !dma_req);
    assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_burst && state == ST_XFER && word_end && !last) |=> dma_req);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> (!pkt_done && !dma_req));
endmodule

// File: rtl/dma_ack_port.sv
// Acknowledge-selected DMA word port: raises a DMA request for a received
// packet and drives buffer words onto a shared tri-state bus while the
// acknowledge and read strobes select it. Assumes synchronous strobes and a
// combinational buffer read port.
module dma_ack_port
    import dma_ack_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1),
    parameter int ADDR_W    = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ack_only,
    input  logic              cfg_burst,
    input  logic              pkt_valid,
    input  logic [CNT_W-1:0]  pkt_words,
    output logic              pkt_done,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic              rd_n,
    output logic              dbus_oe,
    inout  wire  [DATA_W-1:0] dbus
);
    dma_state_e        state;
    logic              load;
    logic              last;
    logic              word_end;
    logic              strobe_en;
    logic [DATA_W-1:0] drive_data;

    // Only a live transfer in acknowledge-only mode may own the bus.
    always_comb strobe_en = cfg_ack_only && (state == ST_XFER);

    dma_req_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_ack_only),
        .cfg_burst  (cfg_burst),
        .pkt_valid  (pkt_valid),
        .pkt_nonzero(pkt_words != '0),
        .dma_ack    (dma_ack),
        .word_end   (word_end),
        .last       (last),
        .state      (state),
        .load       (load),
        .dma_req    (dma_req),
        .pkt_done   (pkt_done)
    );

    dma_word_ctr #(
        .MAX_WORDS(MAX_WORDS),
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_words(pkt_words),
        .step      (word_end),
        .addr      (buf_addr),
        .last      (last)
    );

    dma_bus_strobe #(
        .DATA_W(DATA_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (strobe_en),
        .dma_ack   (dma_ack),
        .rd_n      (rd_n),
        .buf_data  (buf_data),
        .drive     (dbus_oe),
        .drive_data(drive_data),
        .word_end  (word_end)
    );

    // Tri-state driver onto the shared bus.
    assign dbus = dbus_oe ? drive_data : 'z;

    assert_oe_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (dma_ack && !rd_n && cfg_ack_only));
endmodule

// File: tb/sim_dma_ack_port.sv
module sim_dma_ack_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ack_only = 1'b0;
    logic        cfg_burst = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [5:0]  pkt_words = '0;
    logic        pkt_done;
    logic [4:0]  buf_addr;
    logic [15:0] buf_data;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic        rd_n = 1'b1;
    logic        dbus_oe;
    wire  [15:0] dbus;
    logic [7:0]  pkt_id = 8'h00;

    int checks = 0;
    int errors = 0;
    int popped = 0;
    logic [15:0] expq[$];
    logic [4:0]  exp_addr = '0;
    logic        mon_prev = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [15:0] word_of(input logic [7:0] id, input logic [4:0] a);
        return {id, 3'b101, a} ^ 16'h5A00;
    endfunction

    assign buf_data = word_of(pkt_id, buf_addr);

    dma_ack_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ack_only(cfg_ack_only), .cfg_burst(cfg_burst),
        .pkt_valid(pkt_valid), .pkt_words(pkt_words), .pkt_done(pkt_done),
        .buf_addr(buf_addr), .buf_data(buf_data), .dma_req(dma_req),
        .dma_ack(dma_ack), .rd_n(rd_n), .dbus_oe(dbus_oe), .dbus(dbus)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pop one expected word on each new bus drive (R4, R10).
    always @(negedge clk) begin
        #1;
        if (dbus_oe && !mon_prev) begin
            if (expq.size() == 0) chk("R4 unexpected drive", 32'(dbus), 32'hFFFF_FFFF);
            else begin
                chk("R4/R10 bus word", 32'(dbus), 32'(expq.pop_front()));
                popped++;
            end
        end
        mon_prev = dbus_oe;
    end

    // Driver: one acknowledged strobe; returns at the falling edge where it ends.
    task automatic strobe_word(input bit hold_ack, input bit end_by_ack);
        @(negedge clk);
        dma_ack = 1'b1;
        rd_n    = 1'b0;
        expq.push_back(word_of(pkt_id, exp_addr));
        #1 chk("R4 drive on strobe", 32'(dbus_oe), 1);
        @(negedge clk);
        if (end_by_ack) begin
            dma_ack = 1'b0;
            #1 chk("R8 release on ack drop", 32'(dbus_oe), 0);
        end else begin
            rd_n = 1'b1;
            if (!hold_ack) begin end
            #1 chk("R4 release on strobe end", 32'(dbus_oe), 0);
        end
        exp_addr = exp_addr + 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 req", 32'(dma_req), 0);
        chk("R1 oe", 32'(dbus_oe), 0);
        chk("R1 done", 32'(pkt_done), 0);
        chk("R1 addr", 32'(buf_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: mode disabled, packet present, acknowledge ignored
        pkt_id = 8'h11; pkt_words = 6'd3; pkt_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R3 no request", 32'(dma_req), 0);
        dma_ack = 1'b1; rd_n = 1'b0;
        #1 chk("R3 ack ignored", 32'(dbus_oe), 0);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        #1 chk("R3 addr unchanged", 32'(buf_addr), 0);

        // R2: enable single-cycle mode, request rises after one edge
        @(negedge clk);
        cfg_ack_only = 1'b1; cfg_burst = 1'b0; exp_addr = '0;
        @(negedge clk);
        #1 chk("R2 request", 32'(dma_req), 1);
        chk("R2 addr start", 32'(buf_addr), 0);

        // Word 0: ended by rd_n rising
        strobe_word(1'b1, 1'b0);
        @(negedge clk);
        #1 chk("R6 request dropped", 32'(dma_req), 0);
        chk("R5 addr step", 32'(buf_addr), 1);
        dma_ack = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        #1 chk("R6 request re-raised", 32'(dma_req), 1);

        // Word 1: ended by acknowledge dropping while rd_n low
        strobe_word(1'b1, 1'b1);
        @(negedge clk);
        #1 chk("R6 request dropped", 32'(dma_req), 0);
        chk("R5 addr step", 32'(buf_addr), 2);
        rd_n = 1'b1;
        @(negedge clk);
        #1 chk("R6 request re-raised", 32'(dma_req), 1);

        // Word 2: last word
        strobe_word(1'b1, 1'b0);
        @(negedge clk);
        #1 chk("R9 done pulse", 32'(pkt_done), 1);
        chk("R9 request low", 32'(dma_req), 0);
        dma_ack = 1'b0;
        @(negedge clk);
        #1 chk("R9 done one cycle", 32'(pkt_done), 0);
        repeat (3) @(negedge clk);
        #1 chk("R9 no re-request while valid held", 32'(dma_req), 0);

        // Burst mode: 32-word packet after pkt_valid toggles
        pkt_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pkt_id = 8'h2C; pkt_words = 6'd32; cfg_burst = 1'b1; pkt_valid = 1'b1; exp_addr = '0;
        popped = 0;
        @(negedge clk);
        #1 chk("R9 new request after toggle", 32'(dma_req), 1);
        for (int w = 0; w < 32; w++) begin
            strobe_word(1'b1, 1'b0);
            @(negedge clk);
            #1;
            if (w < 31) chk("R7 request held", 32'(dma_req), 1);
            else begin
                chk("R7 request dropped after last", 32'(dma_req), 0);
                chk("R9 done after burst", 32'(pkt_done), 1);
            end
        end
        dma_ack = 1'b0;
        @(negedge clk);
        #2;
        chk("R10 word count", 32'(popped), 32);
        chk("R10 scoreboard empty", 32'(expq.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule